// File: doc/BRIEF.md
# Regulator Control Register Interface over I2C

This block is the serial control port of a multi-output regulator controller. It listens on a two-wire I2C bus as a slave and reaches seven 8-bit control registers: five output-voltage registers, one supervisor control register and one output on/off register. The register contents leave the block as one flat parallel bus for the rest of the chip to use.

A master writes a register by sending the slave address with the write flag, a register pointer byte and one data byte. To read, it sets the pointer in the same way and then addresses the slave with the read flag, either after a repeated START or in a separate transaction after a STOP. The pointer is held across STOP and never steps on its own. SCL and SDA are sampled on the system clock through a synchronizer. SDA is driven open drain through an output enable.

A chip enable input that is low holds the whole block in its default state, and the bus is ignored while it is low.

Top module: `regctl_i2c_top`

## Requirements
- R1: The slave acknowledges only the 7-bit address {6'b000100, addr_sel} (0x08 when addr_sel is 0, 0x09 when it is 1). The eighth bit is the R/W flag, 1 for read. Any other address, including the general call address 0x00, gets no ACK, and SDA stays released until the next START.
- R2: After START, a matching address with write, the pointer byte and one data byte, each byte is acknowledged and the register at the pointer is updated. The new value appears on reg_bus[8*p +: 8].
- R3: In a combined read (address+W, pointer, repeated START, address+R), the slave acknowledges and then returns the addressed register, most significant bit first.
- R4: The pointer is kept after STOP. A later transaction that has only address+R returns the register selected by the earlier pointer-only write, even when transfers to other addresses come in between.
- R5: The pointer never increments or decrements. A read that the master acknowledges returns the same register byte again, and a later read returns it once more.
- R6: When the pointer is above 0x06, the data byte of a write gets no ACK and no register changes. A read at such a pointer returns 0x00.
- R7: Bits with no function read as 0 and ignore writes. Voltage registers 0x00 to 0x04 keep bits 5:0, supervisor register 0x05 keeps all 8 bits, and on/off register 0x06 keeps bits 4:0.
- R8: On reset, and whenever chip_en is low, the registers take their defaults, the pointer returns to 0x00 and SDA is released. The defaults are 0x27, 0x3B, 0x37, 0x3B, 0x3B for 0x00 to 0x04, then 0x06 and 0x07. While chip_en is low, bus traffic gets no ACK.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: Transfers work when each SCL high and low phase lasts at least 4 system clock cycles. This covers both 100 kbit/s and 400 kbit/s with a clock at least 8 times the bit rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable; low holds defaults and ignores the bus |
| addr_sel | input | 1 | Strap that gives the least significant bit of the slave address |
| scl_i | input | 1 | Bus clock as seen at the pad |
| sda_i | input | 1 | Bus data as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_bus | output | 56 | Register 0x00 in bits 7:0, up to register 0x06 in bits 55:48 |

## Verification
The assertions take for granted that the master obeys the bus rules. SDA moves only while SCL is low, except at START and STOP, and the master never drives SDA low while the slave is driving a bit or an ACK. Given that, the slave's drive changes only in low phases. They also take for granted that each SCL phase lasts long enough for the synchronized edges to be seen in order. The bench keeps within these limits. It changes SDA two system cycles after each SCL fall, it holds every phase for 10 or 40 cycles, and it releases SDA whenever the slave is due to drive.

// File: rtl/regctl_i2c_pkg.sv
package regctl_i2c_pkg;

    localparam int DATA_W    = 8;
    localparam int PTR_W     = 8;
    localparam int NUM_VOUT  = 5;
    localparam int SUP_IDX   = NUM_VOUT;
    localparam int ONOFF_IDX = NUM_VOUT + 1;
    localparam int NUM_REGS  = NUM_VOUT + 2;
    localparam int CNT_W     = $clog2(DATA_W + 1);
    localparam logic [5:0] DEV_ID = 6'b000100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_PTR,
        ST_PACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_IGNORE
    } bus_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } pins_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:         return 8'h27;
            1:         return 8'h3B;
            2:         return 8'h37;
            3:         return 8'h3B;
            4:         return 8'h3B;
            SUP_IDX:   return 8'h06;
            ONOFF_IDX: return 8'h07;
            default:   return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        if (idx < NUM_VOUT)    return 8'h3F;
        if (idx == SUP_IDX)    return 8'hFF;
        if (idx == ONOFF_IDX)  return 8'h1F;
        return '0;
    endfunction

endpackage

// File: rtl/regctl_line_sync.sv
module regctl_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/regctl_bus_fsm.sv
module regctl_bus_fsm
    import regctl_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr_q,
    output wr_req_t           wr_req
);
    bus_state_t        state;
    logic              scl_d, sda_d;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              rw_q;
    logic              mack_q;
    bus_evt_t          evt;

    always_comb begin
        evt.start = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop  = scl_s & scl_d & ~sda_d & sda_s;
        evt.rise  = scl_s & ~scl_d;
        evt.fall  = ~scl_s & scl_d;
    end

    wire byte_done = evt.fall && (bitcnt == CNT_W'(DATA_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
            bitcnt <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
            ptr_q  <= '0;
            sda_oe <= 1'b0;
            wr_req <= '0;
        end else begin
            scl_d     <= scl_s;
            sda_d     <= sda_s;
            wr_req.en <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WDAT: begin
                        if (evt.rise) begin
                            rx_sh  <= {rx_sh[DATA_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                if (rx_sh[7:1] == {DEV_ID, addr_lsb}) begin
                                    sda_oe <= 1'b1;
                                    rw_q   <= rx_sh[0];
                                    state  <= ST_AACK;
                                end else begin
                                    state  <= ST_IGNORE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr_q  <= rx_sh;
                                sda_oe <= 1'b1;
                                state  <= ST_PACK;
                            end else begin
                                if (ptr_q < PTR_W'(NUM_REGS)) begin
                                    sda_oe      <= 1'b1;
                                    wr_req.en   <= 1'b1;
                                    wr_req.addr <= ptr_q;
                                    wr_req.data <= rx_sh;
                                    state       <= ST_WACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.fall) begin
                            if (rw_q) begin
                                tx_sh  <= rd_byte;
                                sda_oe <= ~rd_byte[DATA_W-1];
                                bitcnt <= CNT_W'(1);
                                state  <= ST_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_PTR;
                            end
                        end
                    end
                    ST_PACK: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDAT;
                        end
                    end
                    ST_WACK: begin
                        if (evt.fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end
                    end
                    ST_RDAT: begin
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else if (evt.fall) begin
                            sda_oe <= ~tx_sh[3'(4'd7 - 4'(bitcnt))];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) begin
                            mack_q <= ~sda_s;
                        end else if (evt.fall) begin
                            if (mack_q) begin
                                tx_sh  <= rd_byte;
                                sda_oe <= ~rd_byte[DATA_W-1];
                                bitcnt <= CNT_W'(1);
                                state  <= ST_RDAT;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    ST_IDLE, ST_IGNORE: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R9: a change of drive is registered only from a low SCL sample
    p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_d);

    // R1: once the slave has decided to stay out of a transfer it keeps SDA released
    p_ignore_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R5: sending data never moves the pointer
    p_ptr_hold_read_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RDAT || state == ST_RACK) |=> $stable(ptr_q));
endmodule

// File: rtl/regctl_reg_bank.sv
module regctl_reg_bank
    import regctl_i2c_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr_req,
    input  logic [PTR_W-1:0]           rd_ptr,
    output logic [DATA_W-1:0]          rd_byte,
    output logic [NUM_REGS*DATA_W-1:0] flat_q
);
    logic [DATA_W-1:0]          reg_q [NUM_REGS];
    logic [NUM_REGS*DATA_W-1:0] dflt_flat;

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst) begin
                reg_q[i] <= reg_default(i);
            end else if (wr_req.en && wr_req.addr == PTR_W'(i)) begin
                reg_q[i] <= wr_req.data & reg_mask(i);
            end
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_ptr == PTR_W'(i)) rd_byte = reg_q[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            dflt_flat[i*DATA_W +: DATA_W] = reg_default(i);
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign flat_q[g*DATA_W +: DATA_W] = reg_q[g];

        // R7: non-functional bits of every register stay clear
        p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
            (reg_q[g] & ~reg_mask(g)) == '0);
    end

    // R6: the protocol side only issues writes inside the map
    p_write_in_map_r6: assert property (@(posedge clk) disable iff (rst)
        wr_req.en |-> (wr_req.addr < PTR_W'(NUM_REGS)));

    // R8: the cycle after reset or disable shows the default image
    p_defaults_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flat_q == dflt_flat));
endmodule

// File: rtl/regctl_i2c_top.sv
module regctl_i2c_top
    import regctl_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       chip_en,
    input  logic                       addr_sel,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*DATA_W-1:0] reg_bus
);
    localparam int PIN_W = $bits(pins_t);

    logic              srst;
    pins_t             raw_pins, sync_pins;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] rd_byte;
    wr_req_t           wr_req;

    assign srst = rst | ~chip_en;
    assign raw_pins.scl = scl_i;
    assign raw_pins.sda = sda_i;

    regctl_line_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (srst),
        .din  (raw_pins),
        .dout (sync_pins)
    );

    regctl_bus_fsm u_fsm (
        .clk      (clk),
        .rst      (srst),
        .scl_s    (sync_pins.scl),
        .sda_s    (sync_pins.sda),
        .addr_lsb (addr_sel),
        .rd_byte  (rd_byte),
        .sda_oe   (sda_oe),
        .ptr_q    (ptr),
        .wr_req   (wr_req)
    );

    regctl_reg_bank u_bank (
        .clk     (clk),
        .rst     (srst),
        .wr_req  (wr_req),
        .rd_ptr  (ptr),
        .rd_byte (rd_byte),
        .flat_q  (reg_bus)
    );
endmodule

// File: tb/test_regctl_i2c_top.sv
`timescale 1ns/1ps
module test_regctl_i2c_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_en = 1'b1;
    logic        addr_sel = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_line;
    logic        sda_oe;
    logic [55:0] reg_bus;

    int nchk = 0;
    int nfail = 0;
    int hp = 10;
    int viol = 0;
    bit done = 0;
    logic oe_prev = 1'b0;
    logic [7:0] exp_regs [7];

    assign sda_line = ~(m_low | sda_oe);

    always #2.5 clk = ~clk;

    regctl_i2c_top i_regctl_i2c_top (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .addr_sel (addr_sel),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .reg_bus  (reg_bus)
    );

    // ptr, write data, expected read-back
    localparam logic [23:0] VEC [8] = '{
        24'h00FF3F, 24'h010000, 24'h02A525, 24'h035A1A,
        24'h043F3F, 24'h05FFFF, 24'h06FF1F, 24'h058181
    };

    function automatic logic [7:0] dflt(input int i);
        logic [7:0] t [7] = '{8'h27, 8'h3B, 8'h37, 8'h3B, 8'h3B, 8'h06, 8'h07};
        return t[i];
    endfunction

    function automatic logic [7:0] msk(input int i);
        return (i < 5) ? 8'h3F : (i == 5) ? 8'hFF : 8'h1F;
    endfunction

    function automatic logic [55:0] exp_flat();
        logic [55:0] f;
        for (int i = 0; i < 7; i++) f[i*8 +: 8] = exp_regs[i];
        return f;
    endfunction

    task automatic reset_model();
        for (int i = 0; i < 7; i++) exp_regs[i] = dflt(i);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R9 monitor: drive must not move while SCL is high
    always @(negedge clk) begin
        if (!rst && chip_en && sda_oe !== oe_prev && scl) viol++;
        oe_prev <= sda_oe;
    end

    task automatic bus_start();
        m_low = 1'b0; wclk(hp);
        scl = 1'b1;   wclk(hp);
        m_low = 1'b1; wclk(hp);
        scl = 1'b0;   wclk(2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wclk(hp);
        scl = 1'b1;   wclk(hp);
        m_low = 1'b0; wclk(hp);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wclk(hp);
            scl = 1'b1;    wclk(hp);
            scl = 1'b0;    wclk(2);
        end
        m_low = 1'b0; wclk(hp);
        scl = 1'b1;   wclk(hp / 2);
        ack = ~sda_line;
        wclk(hp - hp / 2);
        scl = 1'b0;   wclk(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic master_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wclk(hp);
            scl = 1'b1; wclk(hp / 2);
            b[i] = sda_line;
            wclk(hp - hp / 2);
            scl = 1'b0; wclk(2);
        end
        m_low = master_ack; wclk(hp);
        scl = 1'b1;         wclk(hp);
        scl = 1'b0;         wclk(2);
        m_low = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                            output logic [2:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[2]);
        send_byte(p, acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic do_ptr(input logic [6:0] a, input logic [7:0] p, output logic [1:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[1]);
        send_byte(p, acks[0]);
        bus_stop();
    endtask

    task automatic do_read_comb(input logic [6:0] a, input logic [7:0] p,
                                output logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[2]);
        send_byte(p, acks[1]);
        bus_start();
        send_byte({a, 1'b1}, acks[0]);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    task automatic do_read_only(input logic [6:0] a, output logic [7:0] d, output logic ack);
        bus_start();
        send_byte({a, 1'b1}, ack);
        recv_byte(d, 1'b0);
        bus_stop();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] a3;
        logic [1:0] a2;
        logic       a1;
        logic [7:0] d, d2;

        reset_model();
        wclk(5);
        rst = 1'b0;
        wclk(5);
        chk("R8 reset sda_oe", 64'(sda_oe), 64'd0);
        chk("R8 reset defaults", 64'(reg_bus), 64'(exp_flat()));

        // R1: wrong address and general call are not acknowledged
        do_write(7'h09, 8'h01, 8'h11, a3);
        chk("R1 foreign address nack", 64'(a3[2]), 64'd0);
        do_write(7'h00, 8'h01, 8'h11, a3);
        chk("R1 general call nack", 64'(a3[2]), 64'd0);
        chk("R1 no register change", 64'(reg_bus), 64'(exp_flat()));

        // R2 R3 R7: vector walk at the fast rate
        for (int v = 0; v < 8; v++) begin
            logic [7:0] p, wd, rx;
            p  = VEC[v][23:16];
            wd = VEC[v][15:8];
            rx = VEC[v][7:0];
            do_write(7'h08, p, wd, a3);
            exp_regs[p] = wd & msk(int'(p));
            chk("R2 write acks", 64'(a3), 64'h7);
            chk("R7 masked register image", 64'(reg_bus), 64'(exp_flat()));
            do_read_comb(7'h08, p, d, a3);
            chk("R3 combined read acks", 64'(a3), 64'h7);
            chk("R3 combined read data", 64'(d), 64'(rx));
        end

        // R10: slow bus phases
        hp = 40;
        do_write(7'h08, 8'h03, 8'h11, a3);
        exp_regs[3] = 8'h11;
        chk("R10 slow write acks", 64'(a3), 64'h7);
        do_read_comb(7'h08, 8'h03, d, a3);
        chk("R10 slow read data", 64'(d), 64'h11);
        hp = 10;

        // R4: pointer survives STOP and foreign traffic
        do_ptr(7'h08, 8'h02, a2);
        chk("R4 pointer setup acks", 64'(a2), 64'h3);
        do_write(7'h50, 8'h06, 8'h00, a3);
        chk("R4 foreign transfer nack", 64'(a3[2]), 64'd0);
        do_read_only(7'h08, d, a1);
        chk("R4 separated read ack", 64'(a1), 64'd1);
        chk("R4 separated read data", 64'(d), 64'(exp_regs[2]));

        // R5: acknowledged read repeats the same byte
        bus_start();
        send_byte({7'h08, 1'b1}, a1);
        recv_byte(d, 1'b1);
        recv_byte(d2, 1'b0);
        bus_stop();
        chk("R5 first byte", 64'(d), 64'(exp_regs[2]));
        chk("R5 no increment", 64'(d2), 64'(exp_regs[2]));
        do_read_only(7'h08, d, a1);
        chk("R5 pointer unchanged later", 64'(d), 64'(exp_regs[2]));

        // R6: out-of-map pointer
        do_write(7'h08, 8'h07, 8'h55, a3);
        chk("R6 data nack at 0x07", 64'(a3), 64'h6);
        chk("R6 registers untouched", 64'(reg_bus), 64'(exp_flat()));
        do_read_comb(7'h08, 8'hFF, d, a3);
        chk("R6 read at 0xFF", 64'(d), 64'h00);
        do_write(7'h08, 8'hFF, 8'hAA, a3);
        chk("R6 data nack at 0xFF", 64'(a3[0]), 64'd0);

        // R8: disable restores defaults and ignores the bus
        chip_en = 1'b0;
        wclk(4);
        reset_model();
        chk("R8 disable defaults", 64'(reg_bus), 64'(exp_flat()));
        do_write(7'h08, 8'h01, 8'h00, a3);
        chk("R8 no ack while disabled", 64'(a3), 64'h0);
        chk("R8 disabled keeps defaults", 64'(reg_bus), 64'(exp_flat()));
        chip_en = 1'b1;
        wclk(4);
        do_read_only(7'h08, d, a1);
        chk("R8 pointer back to 0x00", 64'(d), 64'h27);

        // R1: strap selects the low address bit
        addr_sel = 1'b1;
        wclk(4);
        do_write(7'h09, 8'h06, 8'h1E, a3);
        exp_regs[6] = 8'h1E;
        chk("R1 strap high acks 0x09", 64'(a3), 64'h7);
        do_write(7'h08, 8'h06, 8'h01, a3);
        chk("R1 strap high nacks 0x08", 64'(a3[2]), 64'd0);
        chk("R1 register image", 64'(reg_bus), 64'(exp_flat()));

        chk("R9 drive changes only with SCL low", 64'(viol), 64'd0);

        done = 1;
        summary();
        $finish;
    end
endmodule